// File: doc/BRIEF.md
# I2C Wait-State Master

This block is a single-master I2C controller driven through a small register file. Software asks for a start condition, then either writes a byte to be sent or releases the bus so that a byte is clocked in. After each byte the controller parks the bus with SCL held low and pulses an interrupt. Software decides how the next step goes while the bus is parked.

Software chooses whether the pause and its interrupt come after the 8th clock or after the 9th (acknowledge) clock. With the 8th-clock point, software can read a received byte before it decides whether to acknowledge it. Software can also turn on an acknowledge for received bytes, and it can ask for a stop condition.

SCL low and high times are programmable counts of the block clock. The SDA hold time after SCL falls is derived from the low count. Both lines are open-drain and are modelled as pull-low enables plus sampled inputs. Address bytes are formatted by software and sent as ordinary data bytes.

Top module: `i2c_wait_master`

## Requirements
- R1: After reset both lines are released and irq is low. The control register (index 1), the mode register (index 4) and the status register (index 3) read 0. The low-width register (index 5) reads 20 and the high-width register (index 6) reads 16.
- R2: A trigger write (index 2) with bit 0 set produces a start condition only when all of these hold: control bit 0 (enable) is set, mode bit 0 (start output allowed) is set and the bus is idle. In a start condition SDA is pulled low, SCL stays released for the high count and is then pulled low. The controller then parks, shown by status bit 3. In every other case the start trigger has no effect.
- R3: Status bit 0 (bus busy) sets when a start condition (SDA falling while SCL is high) is seen on the pins. It clears when a stop condition (SDA rising while SCL is high) is seen. Status bit 2 (stop seen) sets on a stop condition and clears on a start condition.
- R4: During a byte, SCL is held low for exactly the low-width count and released for exactly the high-width count, in block clock cycles, for each bit.
- R5: SDA changes only while SCL is low. A change happens (low-width >> 2) + 1 cycles after SCL is pulled low.
- R6: A data write (index 0, bits 7:0) while parked after a start or after a 9th clock sends that byte MSB first. SDA is released for the 9th clock. Status bit 1 is set when SDA is found low at the 9th clock and cleared when it is found high.
- R7: A release trigger (trigger bit 2) while parked after a start or after a 9th clock clocks in a byte MSB first. The data register (index 0) then reads that byte.
- R8: With control bit 1 set, the controller parks and pulses irq after the 9th clock. With it clear, the controller parks and pulses irq after the 8th clock with SCL held low. A release from that point runs only the 9th clock, and the controller then parks again without irq.
- R9: With control bit 2 set, SDA is pulled low during the 9th clock of a received byte. With it clear, SDA is left released during that clock.
- R10: A stop trigger (trigger bit 1) while parked pulls SDA low with SCL low, releases SCL, and releases SDA after the high count. irq pulses when the stop completes, and both lines end released.
- R11: irq is high for one cycle per event, and is high exactly once per byte end or stop.
- R12: A control write with bit 0 clear releases both lines, returns the controller to idle and clears status bits 0, 1 and 2.
- R13: A start trigger while the controller is parked has no effect on the lines, the status or irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all widths count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for bus_addr, combinational |
| irq | output | 1 | One-cycle event pulse |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |

## Verification
A bit counter or phase that slips shows within one byte. The bench sees a wrong number of SCL rising edges before the interrupt, a captured byte shifted by one place, or an SCL low or high run that differs from the programmed count. A wrong parked state shows as SCL released while software still holds the transfer, as a missing or doubled interrupt, or as a status word that disagrees after a single register read. Hold-time errors appear as the delay from SCL falling to the next SDA change. A flag that is not cleared shows in the status read that follows a disable or a stop.

// File: rtl/i2c_wait_master.sv
module i2c_wait_master #(
  parameter int CW       = 10,
  parameter int LOW_RST  = 20,
  parameter int HIGH_RST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          scl_i,
  input  logic          sda_i
);
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_TRIG = 3'd2, A_STAT = 3'd3,
                         A_MODE = 3'd4, A_LOW  = 3'd5, A_HIGH = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_WAIT, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt, lowc, highc;
  logic [3:0]    bitn;
  logic [7:0]    shreg;
  logic          rx, hi_ph, mid;
  logic          en, wait9, ack_en, start_en;
  logic          busy, ack_rx, stop_seen;
  logic          scl_q, sda_q, irq_r, scl_low, sda_low;

  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_trig = bus_wr && bus_addr == A_TRIG;
  wire t_start = wr_trig && bus_wdata[0];
  wire t_stop  = wr_trig && bus_wdata[1];
  wire t_rel   = wr_trig && bus_wdata[2];

  wire [CW-1:0] hold     = lowc >> 2;
  wire          low_end  = ({1'b0, cnt} + 1'b1) >= {1'b0, lowc};
  wire          high_end = ({1'b0, cnt} + 1'b1) >= {1'b0, highc};
  wire          drive    = (bitn == 4'd8) ? (rx & ack_en) : (~rx & ~shreg[7]);
  wire          start_det = scl_i & scl_q & sda_q & ~sda_i;
  wire          stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  assign irq    = irq_r;
  assign scl_oe = scl_low;
  assign sda_oe = sda_low;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = CW'(shreg);
      A_CTRL:  bus_rdata = CW'({ack_en, wait9, en});
      A_STAT:  bus_rdata = CW'({st == S_WAIT, stop_seen, ack_rx, busy});
      A_MODE:  bus_rdata = CW'(start_en);
      A_LOW:   bus_rdata = lowc;
      A_HIGH:  bus_rdata = highc;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      rx <= 1'b0; hi_ph <= 1'b0; mid <= 1'b0;
      en <= 1'b0; wait9 <= 1'b0; ack_en <= 1'b0; start_en <= 1'b0;
      lowc <= CW'(LOW_RST); highc <= CW'(HIGH_RST);
      busy <= 1'b0; ack_rx <= 1'b0; stop_seen <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; irq_r <= 1'b0;
      scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (wr_ctrl) {ack_en, wait9, en} <= bus_wdata[2:0];
      if (bus_wr && bus_addr == A_MODE) start_en <= bus_wdata[0];
      if (bus_wr && bus_addr == A_LOW)  lowc  <= bus_wdata;
      if (bus_wr && bus_addr == A_HIGH) highc <= bus_wdata;
      if (en) begin
        if (start_det) begin busy <= 1'b1; stop_seen <= 1'b0; end
        if (stop_det)  begin busy <= 1'b0; stop_seen <= 1'b1; end
      end
      if (wr_ctrl && !bus_wdata[0]) begin
        st <= S_IDLE; cnt <= '0; bitn <= '0; hi_ph <= 1'b0; mid <= 1'b0;
        scl_low <= 1'b0; sda_low <= 1'b0;
        busy <= 1'b0; ack_rx <= 1'b0; stop_seen <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (wr_data) shreg <= bus_wdata[7:0];
            if (t_start && en && start_en && !busy) begin
              st <= S_START; cnt <= '0; sda_low <= 1'b1;
            end
          end
          S_START: begin
            if (high_end) begin
              scl_low <= 1'b1; st <= S_WAIT; mid <= 1'b0; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_WAIT: begin
            cnt <= '0; hi_ph <= 1'b0;
            if (t_stop) st <= S_STOP;
            else if (t_rel) begin
              st <= S_BIT;
              if (!mid) begin rx <= 1'b1; bitn <= '0; end
            end else if (wr_data && !mid) begin
              st <= S_BIT; rx <= 1'b0; bitn <= '0; shreg <= bus_wdata[7:0];
            end
          end
          S_BIT: begin
            if (!hi_ph) begin
              if (cnt == hold) sda_low <= drive;
              if (low_end) begin hi_ph <= 1'b1; cnt <= '0; scl_low <= 1'b0; end
              else cnt <= cnt + 1'b1;
            end else if (high_end) begin
              scl_low <= 1'b1; cnt <= '0; hi_ph <= 1'b0;
              if (bitn == 4'd8) begin
                if (!rx) ack_rx <= ~sda_i;
                st <= S_WAIT; mid <= 1'b0; irq_r <= wait9;
              end else begin
                shreg <= {shreg[6:0], sda_i};
                bitn  <= bitn + 4'd1;
                if (bitn == 4'd7 && !wait9) begin
                  st <= S_WAIT; mid <= 1'b1; irq_r <= 1'b1;
                end
              end
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (!hi_ph) begin
              if (cnt == hold) sda_low <= 1'b1;
              if (low_end) begin hi_ph <= 1'b1; cnt <= '0; scl_low <= 1'b0; end
              else cnt <= cnt + 1'b1;
            end else if (high_end) begin
              sda_low <= 1'b0; st <= S_IDLE; irq_r <= 1'b1; hi_ph <= 1'b0; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wait_master_chk.sv
module i2c_wait_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       en,
  input logic       busy,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  localparam logic [2:0] ST_START = 3'd1, ST_BIT = 3'd2, ST_WAIT = 3'd3;

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_wait_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> scl_oe);

  p_sda_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!scl_oe && !sda_oe));

  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == ST_START) |-> busy);
endmodule

bind i2c_wait_master i2c_wait_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .en(en), .busy(busy),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_wait_master_tb_top.sv
module i2c_wait_master_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bus_wr;
  logic [2:0] bus_addr;
  logic [9:0] bus_wdata;
  wire  [9:0] bus_rdata;
  wire        irq, scl_oe, sda_oe;
  logic       tgt_low;
  wire        scl_i = ~scl_oe;
  wire        sda_i = ~(sda_oe | tgt_low);

  i2c_wait_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_i(scl_i), .sda_i(sda_i)
  );

  int checks = 0, errors = 0;
  int irq_cnt = 0, run_len = 0, last_low = 0, last_high = 0, since = 0, sda_dly = -1, rises = 0;
  int tgt_mode = 0;
  logic [7:0] tgt_byte = 8'h00;
  logic       tgt_ack = 1'b0;
  logic [8:0] cap = '0;
  logic p_scl = 1'b0, p_sda = 1'b0;

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (scl_oe !== p_scl) begin
      if (p_scl) last_low = run_len; else last_high = run_len;
      run_len = 1;
    end else run_len++;
    if (scl_oe && !p_scl) begin
      since = 0;
      if (tgt_mode == 2 && rises < 8) tgt_low = ~tgt_byte[7-rises];
      else if (tgt_mode == 1 && rises == 8) tgt_low = tgt_ack;
      else tgt_low = 1'b0;
    end else since++;
    if (sda_oe !== p_sda && scl_oe && p_scl) sda_dly = since;
    if (!scl_oe && p_scl) begin cap = {cap[7:0], sda_i}; rises++; end
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'(idx); bus_wdata = 10'(val);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output int val);
    @(negedge clk); bus_addr = 3'(idx); #1 val = int'(bus_rdata);
  endtask

  task automatic wait_irq(input int n0);
    for (int k = 0; k < 3000 && irq_cnt == n0; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0); chk("R1 irq", irq, 0);
    rd(3, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 mode", v, 0);
    rd(5, v); chk("R1 low", v, 20);
    rd(6, v); chk("R1 high", v, 16);
  endtask

  task automatic t_start;
    int v, n0;
    wr(5, 8); wr(6, 6); wr(1, 7); wr(4, 0);
    wr(2, 1); repeat (20) @(negedge clk);
    chk("R2 no start without mode", sda_oe, 0);
    rd(3, v); chk("R2 status unchanged", v, 0);
    wr(4, 1); wr(2, 1); repeat (20) @(negedge clk);
    chk("R2 sda low", sda_oe, 1); chk("R2 scl low", scl_oe, 1);
    rd(3, v); chk("R3 busy and parked", v, 9);
    n0 = irq_cnt;
    wr(2, 1); repeat (10) @(negedge clk);
    chk("R13 scl held", scl_oe, 1); chk("R13 sda held", sda_oe, 1);
    rd(3, v); chk("R13 status", v, 9); chk("R13 no irq", irq_cnt, n0);
  endtask

  task automatic t_tx_ack;
    int v, n0;
    tgt_mode = 1; tgt_ack = 1'b1; rises = 0; sda_dly = -1; n0 = irq_cnt;
    wr(0, 8'hA5); wait_irq(n0);
    chk("R6 byte out", int'(cap[8:1]), 8'hA5);
    chk("R6 ack bit on bus", int'(cap[0]), 0);
    chk("R8 nine clocks", rises, 9);
    rd(3, v); chk("R6 ack status", v, 11);
    chk("R4 low width", last_low, 8); chk("R4 high width", last_high, 6);
    chk("R5 hold", sda_dly, 3);
    chk("R8 scl held", scl_oe, 1);
    repeat (5) @(negedge clk);
    chk("R11 one pulse", irq_cnt, n0 + 1);
  endtask

  task automatic t_tx_nack;
    int v, n0;
    wr(5, 13); wr(6, 3);
    tgt_ack = 1'b0; rises = 0; sda_dly = -1; n0 = irq_cnt;
    wr(0, 8'h3C); wait_irq(n0);
    chk("R6 byte out 2", int'(cap[8:1]), 8'h3C);
    rd(3, v); chk("R6 nack status", v, 9);
    chk("R4 low width 2", last_low, 13); chk("R4 high width 2", last_high, 3);
    chk("R5 hold 2", sda_dly, 4);
  endtask

  task automatic t_rx8;
    int v, n0, n1;
    wr(1, 5);
    tgt_mode = 2; tgt_byte = 8'h5A; rises = 0;
    @(negedge clk); tgt_low = ~tgt_byte[7];
    n0 = irq_cnt;
    wr(2, 4); wait_irq(n0);
    chk("R8 eight clocks", rises, 8);
    chk("R7 bus byte", int'(cap[7:0]), 8'h5A);
    rd(0, v); chk("R7 data reg", v, 8'h5A);
    chk("R8 scl held at 8", scl_oe, 1);
    n1 = irq_cnt;
    wr(2, 4); repeat (60) @(negedge clk);
    chk("R8 ninth clock", rises, 9);
    chk("R9 ack driven", int'(cap[0]), 0);
    chk("R8 no irq after 9th", irq_cnt, n1);
    rd(3, v); chk("R8 parked", v, 9);
  endtask

  task automatic t_rx9;
    int v, n0;
    wr(1, 3);
    tgt_byte = 8'hC3; rises = 0;
    @(negedge clk); tgt_low = ~tgt_byte[7];
    n0 = irq_cnt;
    wr(2, 4); wait_irq(n0);
    chk("R8 nine clocks rx", rises, 9);
    chk("R7 bus byte 2", int'(cap[8:1]), 8'hC3);
    chk("R9 no ack", int'(cap[0]), 1);
    rd(0, v); chk("R7 data reg 2", v, 8'hC3);
  endtask

  task automatic t_stop;
    int v, n0;
    tgt_mode = 0; tgt_low = 1'b0; n0 = irq_cnt;
    wr(2, 2); wait_irq(n0);
    repeat (3) @(negedge clk);
    chk("R10 scl released", scl_oe, 0); chk("R10 sda released", sda_oe, 0);
    chk("R10 stop irq", irq_cnt, n0 + 1);
    rd(3, v); chk("R3 stop seen, idle", v, 4);
  endtask

  task automatic t_disable;
    int v, n0;
    wr(1, 7); wr(2, 1); repeat (20) @(negedge clk);
    tgt_mode = 1; tgt_ack = 1'b1; rises = 0; n0 = irq_cnt;
    wr(0, 8'h81); wait_irq(n0);
    rd(3, v); chk("R3 stop cleared by start", v, 11);
    tgt_mode = 0;
    wr(1, 0); repeat (2) @(negedge clk);
    chk("R12 scl released", scl_oe, 0); chk("R12 sda released", sda_oe, 0);
    rd(3, v); chk("R12 status cleared", v, 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; tgt_low = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start();
    t_tx_ack();
    t_tx_nack();
    t_rx8();
    t_rx9();
    t_stop();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule